// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block sits beside the execution core of an 8-bit processor and decides, at each instruction boundary, whether an interrupt has to be entered. It weighs three sources. Reset always runs first. After reset, an NMI edge outranks the maskable IRQ, and the maskable IRQ is a set of level sources ORed with a one-shot request. When an entry is accepted, the block raises `busy` to stall instruction fetch. It then pushes the return address and a copy of the status onto the page-one stack, fetches the matching vector through its memory port, and hands the new PC, stack pointer and status back to the core through load strobes.

The core reports the instruction boundary with `boundary`. It also supplies the I flag as it stood before the last instruction (`i_prev`) and the current PC, SP and status. After a reset the block runs a short vector fetch with no stack activity. A jammed core takes no interrupts until the next reset.

Top module: `intr_entry_seq`

## Requirements
- R1: After `rst_n` is released, `busy` is high for exactly 3 cycles. The block reads 0xFFFC (low byte) and 0xFFFD (high byte), pulses `pc_we` with that address and `status_we` with `status_out` = 0x04, writes no stack byte, never pulses `sp_we`, and `jammed` is 0.
- R2: An entry starts only when `boundary` is high while the block is idle and a request is pending. `busy` then rises on the next cycle and stays high for exactly 7 cycles. When no request is accepted, `busy` stays low.
- R3: An entry writes three bytes at address 0x0100 + SP: PC[15:8], then PC[7:0], then the status. SP is decremented after each write, wrapping within page one, and `sp_out` = SP - 3 is loaded with `sp_we`.
- R4: The pushed status byte equals `status_in` with bit 4 cleared and bit 5 set.
- R5: An NMI entry loads the PC from 0xFFFA (low) and 0xFFFB (high) and writes the status back unchanged.
- R6: An IRQ entry loads the PC from 0xFFFE (low) and 0xFFFF (high) and writes the status back with bit 2 (I) set.
- R7: The IRQ is accepted only when `i_prev` is 0. A pending NMI is accepted whatever the value of `i_prev`.
- R8: When an NMI and an IRQ are both pending at a boundary, the NMI is entered.
- R9: An NMI request is the rising edge of `nmi`, held pending until it is serviced. Keeping `nmi` high produces only one entry.
- R10: A one-shot pulse on `irq_shot` is cleared once an IRQ entry services it. Any bit of `irq_lvl` keeps requesting until its owner drops it.
- R11: Once `jam_set` has pulsed, `jammed` is 1 and no NMI or IRQ is entered. Requests that arrive while jammed are discarded. Reset clears `jammed`.
- R12: `mem_re` is asserted only for vector addresses (upper 12 bits 0xFFF), and `mem_we` is asserted only for page-one addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the reset vector fetch on release |
| boundary | input | 1 | Instruction boundary strobe from the core |
| nmi | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_lvl | input | N_IRQ | Level-sensitive maskable request sources |
| irq_shot | input | 1 | One-cycle pulse that latches a one-shot IRQ |
| i_prev | input | 1 | I flag sampled before the last instruction |
| jam_set | input | 1 | Core has entered the jammed state |
| pc_in | input | 16 | Current return address |
| sp_in | input | 8 | Current stack pointer |
| status_in | input | 8 | Current status register |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_re` |
| busy | output | 1 | Entry sequence active; the core must stall fetch |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| pc_out | output | 16 | New program counter |
| pc_we | output | 1 | Load strobe for `pc_out` |
| sp_out | output | 8 | New stack pointer |
| sp_we | output | 1 | Load strobe for `sp_out` |
| status_out | output | 8 | New status register |
| status_we | output | 1 | Load strobe for `status_out` |
| jammed | output | 1 | Core is jammed; interrupts are ignored |

## Verification
Some properties are checked by assertions on every cycle. Stack writes must stay in page one, and consecutive pushes must step the address down by one. The third push must carry bit 5 set and bit 4 clear. Reads must touch only the vector region, a busy stretch must never exceed seven cycles, and a jammed idle block must never start an entry. Other behaviours can only be shown by the bench's scenarios: which vector wins when NMI and IRQ collide, the effect of the mask sampled before the instruction, the one-shot request being consumed while a level source survives, a held NMI producing a single entry, and requests made during a jam being lost across reset.

// File: rtl/intr_entry_seq.sv
module intr_entry_seq #(
  parameter int N_IRQ = 4,
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             nmi,
  input  logic [N_IRQ-1:0] irq_lvl,
  input  logic             irq_shot,
  input  logic             i_prev,
  input  logic             jam_set,
  input  logic [15:0]      pc_in,
  input  logic [7:0]       sp_in,
  input  logic [7:0]       status_in,
  input  logic [7:0]       mem_rdata,
  output logic             busy,
  output logic [15:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             mem_we,
  output logic             mem_re,
  output logic [15:0]      pc_out,
  output logic             pc_we,
  output logic [7:0]       sp_out,
  output logic             sp_we,
  output logic [7:0]       status_out,
  output logic             status_we,
  output logic             jammed
);
  typedef enum logic [2:0] {S_IDLE, S_ARB, S_PH, S_PL, S_PP, S_VL, S_VH, S_FIN} state_t;
  typedef enum logic [1:0] {K_RST, K_NMI, K_IRQ} kind_t;

  state_t      st;
  kind_t       kind;
  logic [7:0]  sp_r, stat_r, vlo, vhi;
  logic [15:0] pc_r;
  logic        nmi_q, nmi_pend, shot_pend, jam_r;

  wire nmi_edge = nmi & ~nmi_q;
  wire irq_req  = (|irq_lvl) | shot_pend;
  wire idle     = (st == S_IDLE);
  wire take_nmi = boundary & idle & ~jam_r & nmi_pend;
  wire take_irq = boundary & idle & ~jam_r & ~nmi_pend & irq_req & ~i_prev;
  wire take     = take_nmi | take_irq;
  wire pushing  = (st == S_PH) | (st == S_PL) | (st == S_PP);

  logic [15:0] vec;
  always_comb begin
    case (kind)
      K_NMI:   vec = 16'hFFFA;
      K_IRQ:   vec = 16'hFFFE;
      default: vec = 16'hFFFC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_VL;
      kind <= K_RST;
      sp_r <= '0;
      stat_r <= '0;
      pc_r <= '0;
      vlo <= '0;
      vhi <= '0;
      nmi_q <= 1'b0;
      nmi_pend <= 1'b0;
      shot_pend <= 1'b0;
      jam_r <= 1'b0;
    end else begin
      nmi_q <= nmi;
      if (jam_set) jam_r <= 1'b1;
      if (take_nmi) nmi_pend <= 1'b0;
      if (nmi_edge) nmi_pend <= 1'b1;
      if (take_irq) shot_pend <= 1'b0;
      if (irq_shot) shot_pend <= 1'b1;
      if (jam_r | jam_set) begin
        nmi_pend <= 1'b0;
        shot_pend <= 1'b0;
      end
      if (pushing) sp_r <= sp_r - 8'd1;
      case (st)
        S_IDLE: if (take) begin
          st <= S_ARB;
          kind <= take_nmi ? K_NMI : K_IRQ;
          pc_r <= pc_in;
          sp_r <= sp_in;
          stat_r <= status_in;
        end
        S_ARB: st <= S_PH;
        S_PH:  st <= S_PL;
        S_PL:  st <= S_PP;
        S_PP:  st <= S_VL;
        S_VL: begin vlo <= mem_rdata; st <= S_VH; end
        S_VH: begin vhi <= mem_rdata; st <= S_FIN; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = ~idle;
  assign jammed    = jam_r;
  assign mem_we    = pushing;
  assign mem_re    = (st == S_VL) | (st == S_VH);
  assign mem_addr  = pushing ? {STACK_PAGE, sp_r} :
                     (st == S_VL) ? vec :
                     (st == S_VH) ? (vec | 16'h0001) : 16'h0000;
  assign mem_wdata = (st == S_PH) ? pc_r[15:8] :
                     (st == S_PL) ? pc_r[7:0] :
                     (st == S_PP) ? ((stat_r & ~8'h10) | 8'h20) : 8'h00;

  wire fin = (st == S_FIN);
  assign pc_we      = fin;
  assign pc_out     = {vhi, vlo};
  assign sp_we      = fin & (kind != K_RST);
  assign sp_out     = sp_r;
  assign status_we  = fin;
  assign status_out = (kind == K_RST) ? 8'h04 :
                      (kind == K_IRQ) ? (stat_r | 8'h04) : stat_r;
endmodule

module intr_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        jammed,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata
);
  logic [3:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (busy) run_len <= run_len + 4'd1;
    else run_len <= '0;
  end

  assert_stack_page_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == 8'h01);
  assert_push_descend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr[7:0] == $past(mem_addr[7:0]) - 8'd1);
  assert_status_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) && $past(mem_we, 2) |-> mem_wdata[5] && !mem_wdata[4]);
  assert_vector_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> mem_addr[15:4] == 12'hFFF);
  assert_jam_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    jammed && !busy |=> !busy);
  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < 4'd7);
endmodule

bind intr_entry_seq intr_entry_seq_chk chk_i (.*);

// File: tb/intr_entry_seq_tb.sv
module intr_entry_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic boundary = 0, nmi = 0, irq_shot = 0, i_prev = 1, jam_set = 0;
  logic [3:0] irq_lvl = '0;
  logic [15:0] pc_in = '0;
  logic [7:0] sp_in = '0, status_in = '0, mem_rdata;
  logic busy, mem_we, mem_re, pc_we, sp_we, status_we, jammed;
  logic [15:0] mem_addr, pc_out;
  logic [7:0] mem_wdata, sp_out, status_out;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  intr_entry_seq dut_i (.*);

  logic [7:0] stk [256];
  int stack_writes = 0;
  always @(posedge clk) if (mem_we) begin
    stk[mem_addr[7:0]] <= mem_wdata;
    stack_writes <= stack_writes + 1;
  end

  always_comb begin
    case (mem_addr)
      16'hFFFA: mem_rdata = 8'h34;
      16'hFFFB: mem_rdata = 8'h12;
      16'hFFFC: mem_rdata = 8'h00;
      16'hFFFD: mem_rdata = 8'h80;
      16'hFFFE: mem_rdata = 8'h78;
      16'hFFFF: mem_rdata = 8'h56;
      default:  mem_rdata = 8'hEA;
    endcase
  end

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int nbusy; logic got, spw; logic [15:0] gpc; logic [7:0] gsp, gst;

  task automatic observe(input int cycles);
    nbusy = 0; got = 0; spw = 0; gpc = '0; gsp = '0; gst = '0;
    for (int i = 0; i < cycles; i++) begin
      if (busy) nbusy++;
      if (sp_we) begin spw = 1; gsp = sp_out; end
      if (pc_we) begin got = 1; gpc = pc_out; gst = status_out; end
      @(negedge clk);
    end
  endtask

  task automatic probe();
    boundary = 1; @(negedge clk); boundary = 0;
    observe(12);
  endtask

  task automatic setup(input logic nm, input logic [3:0] lv, input logic sh, input logic ip,
                       input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] st);
    @(negedge clk);
    nmi = nm; irq_shot = sh; irq_lvl = lv; i_prev = ip; pc_in = pc; sp_in = sp; status_in = st;
    @(negedge clk);
    nmi = 0; irq_shot = 0;
  endtask

  typedef struct packed {
    logic nm; logic [3:0] lv; logic sh; logic ip;
    logic [15:0] pc; logic [7:0] sp; logic [7:0] st;
    logic take; logic [15:0] epc; logic [7:0] est;
  } case_t;

  localparam case_t CASES [8] = '{
    '{1'b1, 4'h0, 1'b0, 1'b0, 16'hC123, 8'hFF, 8'hC3, 1'b1, 16'h1234, 8'hC3},
    '{1'b0, 4'h1, 1'b0, 1'b0, 16'h2000, 8'h80, 8'h11, 1'b1, 16'h5678, 8'h15},
    '{1'b0, 4'h2, 1'b0, 1'b1, 16'h3000, 8'h70, 8'h04, 1'b0, 16'h0000, 8'h00},
    '{1'b1, 4'h4, 1'b0, 1'b0, 16'h4000, 8'h60, 8'h00, 1'b1, 16'h1234, 8'h00},
    '{1'b1, 4'h0, 1'b0, 1'b1, 16'h5000, 8'h50, 8'h04, 1'b1, 16'h1234, 8'h04},
    '{1'b0, 4'h0, 1'b1, 1'b0, 16'h6000, 8'h40, 8'h80, 1'b1, 16'h5678, 8'h84},
    '{1'b0, 4'h8, 1'b0, 1'b0, 16'h7000, 8'h01, 8'hFF, 1'b1, 16'h5678, 8'hFF},
    '{1'b0, 4'h0, 1'b0, 1'b0, 16'h7777, 8'h33, 8'h00, 1'b0, 16'h0000, 8'h00}
  };

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset vector fetch
    rst_n = 1;
    observe(8);
    check(16'(nbusy), 16'd3, "R1 busy length");
    check(16'(got), 16'd1, "R1 pc load");
    check(gpc, 16'h8000, "R1 reset vector");
    check({8'h0, gst}, 16'h0004, "R1 status I only");
    check(16'(spw), 16'd0, "R1 no sp load");
    check(16'(stack_writes), 16'd0, "R1 no stack writes");
    check(16'(jammed), 16'd0, "R1 not jammed");

    // R2..R8 table walk
    foreach (CASES[k]) begin
      logic [7:0] a1, a2, ps;
      setup(CASES[k].nm, CASES[k].lv, CASES[k].sh, CASES[k].ip, CASES[k].pc, CASES[k].sp, CASES[k].st);
      probe();
      irq_lvl = '0;
      a1 = CASES[k].sp - 8'd1;
      a2 = CASES[k].sp - 8'd2;
      ps = (CASES[k].st & ~8'h10) | 8'h20;
      check(16'(got), 16'(CASES[k].take), $sformatf("R2/R7 taken case %0d", k));
      if (CASES[k].take) begin
        check(16'(nbusy), 16'd7, $sformatf("R2 busy length case %0d", k));
        check(gpc, CASES[k].epc, $sformatf("R5/R6/R8 vector case %0d", k));
        check({8'h0, gst}, {8'h0, CASES[k].est}, $sformatf("R5/R6 status case %0d", k));
        check({8'h0, gsp}, {8'h0, CASES[k].sp - 8'd3}, $sformatf("R3 sp case %0d", k));
        check({8'h0, stk[CASES[k].sp]}, {8'h0, CASES[k].pc[15:8]}, $sformatf("R3 push hi case %0d", k));
        check({8'h0, stk[a1]}, {8'h0, CASES[k].pc[7:0]}, $sformatf("R3 push lo case %0d", k));
        check({8'h0, stk[a2]}, {8'h0, ps}, $sformatf("R4 pushed status case %0d", k));
      end else begin
        check(16'(nbusy), 16'd0, $sformatf("R2 idle case %0d", k));
      end
    end

    // R10 one-shot consumed
    setup(1'b0, 4'h0, 1'b1, 1'b0, 16'h1000, 8'hF0, 8'h00);
    probe();
    check(16'(got), 16'd1, "R10 one-shot taken");
    probe();
    check(16'(got), 16'd0, "R10 one-shot cleared");

    // R10 level persists after NMI wins (R8)
    setup(1'b1, 4'h2, 1'b0, 1'b0, 16'h1100, 8'hE0, 8'h00);
    probe();
    check(gpc, 16'h1234, "R8 NMI first");
    probe();
    check(gpc, 16'h5678, "R10 level IRQ still requesting");
    irq_lvl = '0;

    // R9 held NMI gives one entry
    @(negedge clk); nmi = 1; i_prev = 1;
    @(negedge clk);
    probe();
    check(16'(got), 16'd1, "R9 held NMI first entry");
    probe();
    check(16'(got), 16'd0, "R9 held NMI no second entry");
    nmi = 0;

    // R11 jam
    @(negedge clk); jam_set = 1;
    @(negedge clk); jam_set = 0;
    check(16'(jammed), 16'd1, "R11 jammed flag");
    setup(1'b1, 4'h1, 1'b1, 1'b0, 16'h2222, 8'hD0, 8'h00);
    probe();
    check(16'(nbusy), 16'd0, "R11 no entry while jammed");
    irq_lvl = '0;
    rst_n = 0; @(negedge clk); rst_n = 1;
    observe(8);
    check(16'(jammed), 16'd0, "R11 reset clears jam");
    check(gpc, 16'h8000, "R1 reset after jam");
    i_prev = 0;
    probe();
    check(16'(got), 16'd0, "R11 jammed requests discarded");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule